// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Dead Time

This block drives the six gate signals of a three-phase bridge. One up-counter, shared by all phases, sets an edge-aligned carrier. Each phase compares that count against its own threshold to form a reference level. A dead-band stage then splits the reference into a high-side gate and a low-side gate. Whenever one side switches off, the other side is held off for a programmable number of clock cycles before it may switch on, so the two switches of one leg never conduct together.

Each phase has a mode select that picks one of four sources for its reference: compare-based PWM, constant high, constant low, or hold-last-value. This allows six-step commutation patterns. Two enables per phase choose which gate actually switches, so PWM can sit on the high side or the low side. A master enable parks all six gates high when it is off. The period, the thresholds and the dead time are shadowed and only take effect when the counter wraps. Mode, enables and the master enable act at once. All inputs are plain control levels, with no stream handshake.

Top module: `cpwm_gen`

## Requirements
- R1: While reset is asserted all six gate outputs are low. After reset the shadow registers hold a period of 2250 counts, a threshold of 100 on every phase and a dead time of 10 cycles, and these apply until the first counter wrap.
- R2: The counter runs 0, 1, …, P-1 and then returns to 0, where P is the shadowed period. The period input is copied into the shadow only at that wrap, so a change first alters the length of the following period.
- R3: In PWM mode (mode code 0), a phase's reference is high while the count is below that phase's threshold. With only the high-side gate enabled, the gate is high for exactly threshold cycles in each period.
- R4: Threshold and dead-time inputs are copied into their shadows only at the counter wrap. A change made mid-period leaves the pulse of the running period unchanged.
- R5: Mode code 1 forces the reference high and mode code 2 forces it low, independent of the count.
- R6: Mode code 3 holds the reference at the value it had when the mode was entered.
- R7: With both gates of a phase enabled and the master enable on, the high and low gates are never high together. Each gate turns on exactly D cycles after its partner turns off, where D is the shadowed dead time. Per period the high gate is on threshold-D cycles, the low gate is on P-threshold-D cycles, and both are off for 2·D cycles.
- R8: A reference pulse no longer than D cycles produces no pulse at all on the gate it would have turned on.
- R9: With only the high-side enable set, the high gate follows the reference without dead time and the low gate stays low. With only the low-side enable set, the low gate carries the inverted reference without dead time and the high gate stays low. With neither set, both gates stay low.
- R10: When the master enable is low, all six gates are high from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Period in counts, shadowed at wrap |
| cmp_i | input | NCH*CNT_W | Per-phase threshold; phase c at bits c*CNT_W upward |
| dtime_i | input | DT_W | Dead time in clock cycles, shadowed at wrap |
| mode_i | input | 2*NCH | Per-phase mode; phase c at bits 2c+1:2c (0 PWM, 1 high, 2 low, 3 hold) |
| en_hi_i | input | NCH | Per-phase high-side gate enable |
| en_lo_i | input | NCH | Per-phase low-side gate enable |
| moe_i | input | 1 | Master output enable; low parks all gates high |
| gate_hi_o | output | NCH | High-side gate drives |
| gate_lo_o | output | NCH | Low-side gate drives |

## Verification
Several properties are checked on every cycle: the counter stays inside the shadowed period, shadows change only at a wrap, forced and hold modes fix the reference, the two gates of a leg never overlap while the master enable is on, idle parking follows a low master enable, and a disabled gate stays low. The exact dead-band widths, pulse suppression, and the per-period on-time budget under each enable combination can only be shown by the bench. It counts gate cycles over whole periods. The same holds for the reset defaults and for the one-period delay of preloaded values, which the bench measures pulse by pulse.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    MODE_PWM  = 2'd0,
    MODE_FHI  = 2'd1,
    MODE_FLO  = 2'd2,
    MODE_HOLD = 2'd3
  } ch_mode_e;
endpackage

// File: rtl/cpwm_timebase.sv
// Shared edge-aligned up-counter with shadowed period and dead time.
module cpwm_timebase #(
  parameter int CNT_W      = 12,
  parameter int DT_W       = 8,
  parameter int DEF_PERIOD = 2250,
  parameter int DEF_DT     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [DT_W-1:0]  dtime_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [DT_W-1:0]  dt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] RST_PER = CNT_W'(DEF_PERIOD);
  localparam logic [DT_W-1:0]  RST_DT  = DT_W'(DEF_DT);

  logic [CNT_W-1:0] per_q, cnt_q, last_c;
  logic [DT_W-1:0]  dt_q;

  // A zero period behaves as a period of one count.
  assign last_c = (per_q == '0) ? '0 : per_q - 1'b1;
  assign wrap_o = (cnt_q >= last_c);
  assign cnt_o  = cnt_q;
  assign dt_o   = dt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= RST_PER;
      dt_q  <= RST_DT;
    end else if (wrap_o) begin
      cnt_q <= '0;
      per_q <= period_i;
      dt_q  <= dtime_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: count never leaves the shadowed period
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_c);
  // R2: period shadow only moves at a wrap
  p_per_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_o |=> $stable(per_q));
  // R4: dead-time shadow only moves at a wrap
  p_dt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_o |=> $stable(dt_q));
endmodule

// File: rtl/cpwm_refgen.sv
// Per-phase reference: threshold shadow plus mode decode.
module cpwm_refgen
  import cpwm_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int DEF_CMP = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  ch_mode_e         mode_i,
  output logic             ref_o
);
  localparam logic [CNT_W-1:0] RST_CMP = CNT_W'(DEF_CMP);

  logic [CNT_W-1:0] cmp_q;
  logic             ref_q;

  assign ref_o = ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= RST_CMP;
    end else if (wrap_i) begin
      cmp_q <= cmp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
    end else begin
      unique case (mode_i)
        MODE_PWM: ref_q <= (cnt_i < cmp_q);
        MODE_FHI: ref_q <= 1'b1;
        MODE_FLO: ref_q <= 1'b0;
        default:  ref_q <= ref_q;
      endcase
    end
  end

  // R4: threshold shadow only moves at a wrap
  p_cmp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(cmp_q));
  // R5: forced levels
  p_force_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_FHI) |=> ref_o);
  p_force_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_FLO) |=> !ref_o);
  // R6: hold keeps the reference
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_HOLD) |=> $stable(ref_o));
endmodule

// File: rtl/cpwm_deadband.sv
// Splits one reference into high/low gates with a dead-band counter.
module cpwm_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dt_i,
  input  logic            en_hi_i,
  input  logic            en_lo_i,
  input  logic            moe_i,
  output logic            hi_o,
  output logic            lo_o
);
  logic            ref_d;
  logic [DT_W-1:0] dcnt_q;
  logic            settled;
  logic            hi_n, lo_n;

  assign settled = (dcnt_q == '0);

  // Each reference edge restarts the wait; a second edge before expiry
  // restarts it again, so a short pulse never reaches the gate.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d  <= 1'b0;
      dcnt_q <= '0;
    end else begin
      ref_d <= ref_i;
      if (ref_i != ref_d) begin
        dcnt_q <= dt_i;
      end else if (!settled) begin
        dcnt_q <= dcnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    if (!moe_i) begin
      hi_n = 1'b1;
      lo_n = 1'b1;
    end else begin
      unique case ({en_hi_i, en_lo_i})
        2'b11: begin
          hi_n = ref_d & settled;
          lo_n = ~ref_d & settled;
        end
        2'b10: begin
          hi_n = ref_d;
          lo_n = 1'b0;
        end
        2'b01: begin
          hi_n = 1'b0;
          lo_n = ~ref_d;
        end
        default: begin
          hi_n = 1'b0;
          lo_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_o <= 1'b0;
      lo_o <= 1'b0;
    end else begin
      hi_o <= hi_n;
      lo_o <= lo_n;
    end
  end

  // R7: no shoot-through while outputs are live
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_o && lo_o) |-> !$past(moe_i));
  // R10: idle parking
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(moe_i)) |-> (hi_o && lo_o));
  // R9: disabled gates stay low
  p_hi_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(moe_i) && !$past(en_hi_i)) |-> !hi_o);
  p_lo_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(moe_i) && !$past(en_lo_i)) |-> !lo_o);
endmodule

// File: rtl/cpwm_gen.sv
// Three-phase complementary PWM generator, top level.
module cpwm_gen
  import cpwm_pkg::*;
#(
  parameter int NCH        = 3,
  parameter int CNT_W      = 12,
  parameter int DT_W       = 8,
  parameter int DEF_PERIOD = 2250,
  parameter int DEF_CMP    = 100,
  parameter int DEF_DT     = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   period_i,
  input  logic [NCH*CNT_W-1:0] cmp_i,
  input  logic [DT_W-1:0]    dtime_i,
  input  logic [2*NCH-1:0]   mode_i,
  input  logic [NCH-1:0]     en_hi_i,
  input  logic [NCH-1:0]     en_lo_i,
  input  logic               moe_i,
  output logic [NCH-1:0]     gate_hi_o,
  output logic [NCH-1:0]     gate_lo_o
);
  logic [CNT_W-1:0] cnt;
  logic [DT_W-1:0]  dt;
  logic             wrap;
  logic [NCH-1:0]   ref_v;

  cpwm_timebase #(
    .CNT_W(CNT_W), .DT_W(DT_W), .DEF_PERIOD(DEF_PERIOD), .DEF_DT(DEF_DT)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .dtime_i(dtime_i),
    .cnt_o(cnt), .dt_o(dt), .wrap_o(wrap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_phase
    cpwm_refgen #(.CNT_W(CNT_W), .DEF_CMP(DEF_CMP)) u_ref (
      .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .cnt_i(cnt),
      .cmp_i(cmp_i[c*CNT_W +: CNT_W]),
      .mode_i(ch_mode_e'(mode_i[2*c +: 2])),
      .ref_o(ref_v[c])
    );
    cpwm_deadband #(.DT_W(DT_W)) u_db (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_v[c]), .dt_i(dt),
      .en_hi_i(en_hi_i[c]), .en_lo_i(en_lo_i[c]), .moe_i(moe_i),
      .hi_o(gate_hi_o[c]), .lo_o(gate_lo_o[c])
    );
  end
endmodule

// File: tb/test_cpwm_gen.sv
module test_cpwm_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int CW  = 12;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0]     period_i = 12'd40;
  logic [NCH*CW-1:0] cmp_i = '0;
  logic [DW-1:0]     dtime_i = 8'd3;
  logic [2*NCH-1:0]  mode_i = '0;
  logic [NCH-1:0]    en_hi = '1;
  logic [NCH-1:0]    en_lo = '0;
  logic              moe = 1'b1;
  logic [NCH-1:0]    hi, lo;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpwm_gen i_cpwm_gen (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .cmp_i(cmp_i),
    .dtime_i(dtime_i), .mode_i(mode_i), .en_hi_i(en_hi), .en_lo_i(en_lo),
    .moe_i(moe), .gate_hi_o(hi), .gate_lo_o(lo)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cmp(input int ch, input int v);
    cmp_i[ch*CW +: CW] = CW'(v);
  endtask

  task automatic set_mode(input int ch, input int m);
    mode_i[2*ch +: 2] = 2'(m);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Count gate activity over n cycles.
  task automatic window(input int ch, input int n, output int nh, output int nl,
                        output int ng, output int no);
    nh = 0; nl = 0; ng = 0; no = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hi[ch]) nh++;
      if (lo[ch]) nl++;
      if (!hi[ch] && !lo[ch]) ng++;
      if (hi[ch] && lo[ch]) no++;
    end
  endtask

  task automatic wait_rise(input int ch);
    logic p;
    p = hi[ch];
    @(negedge clk);
    while (!(hi[ch] && !p)) begin
      p = hi[ch];
      @(negedge clk);
    end
  endtask

  // Called on the cycle the high gate rose; returns width and rise-to-rise.
  task automatic pulse(input int ch, output int w, output int per);
    logic p;
    w = 0; per = 0;
    do begin
      per++;
      if (hi[ch]) w++;
      p = hi[ch];
      @(negedge clk);
    end while (!(hi[ch] && !p));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset high gates", int'(hi), 0);
    check("R1 reset low gates", int'(lo), 0);
  endtask

  task automatic t_defaults();
    int w, p;
    for (int c = 0; c < NCH; c++) begin set_cmp(c, 12); set_mode(c, 0); end
    period_i = 12'd40; dtime_i = 8'd3; en_hi = '1; en_lo = '0; moe = 1'b1;
    do_reset();
    wait_rise(0);
    pulse(0, w, p);
    check("R1 default threshold width", w, 100);
    check("R1 R2 default period", p, 2250);
    pulse(0, w, p);
    check("R3 R4 new threshold width", w, 12);
    check("R2 new period", p, 40);
  endtask

  task automatic t_default_dt();
    int w, p;
    en_hi = '1; en_lo = '1;
    do_reset();
    wait_rise(0);
    pulse(0, w, p);
    check("R1 R7 default dead time width", w, 90);
    repeat (100) @(negedge clk);
  endtask

  task automatic t_dead();
    int nh, nl, ng, no;
    set_cmp(0, 12); set_cmp(1, 25); set_cmp(2, 3);
    en_hi = '1; en_lo = '1;
    repeat (100) @(negedge clk);
    window(0, 80, nh, nl, ng, no);
    check("R7 ch0 high on", nh, 18);
    check("R7 ch0 low on", nl, 50);
    check("R7 ch0 dead cycles", ng, 12);
    check("R7 ch0 overlap", no, 0);
    window(1, 80, nh, nl, ng, no);
    check("R7 ch1 high on", nh, 44);
    check("R7 ch1 low on", nl, 24);
    check("R7 ch1 overlap", no, 0);
    window(2, 80, nh, nl, ng, no);
    check("R8 short pulse suppressed", nh, 0);
    check("R8 ch2 low on", nl, 68);
  endtask

  task automatic t_single();
    int nh, nl, ng, no;
    en_hi = 3'b010; en_lo = 3'b001;
    repeat (10) @(negedge clk);
    window(0, 80, nh, nl, ng, no);
    check("R9 low-only high gate", nh, 0);
    check("R9 low-only inverted ref", nl, 56);
    window(1, 80, nh, nl, ng, no);
    check("R9 high-only ref", nh, 50);
    check("R9 high-only low gate", nl, 0);
    window(2, 80, nh, nl, ng, no);
    check("R9 none high", nh, 0);
    check("R9 none low", nl, 0);
  endtask

  task automatic t_force();
    int nh, nl, ng, no;
    en_hi = '1; en_lo = '1;
    set_mode(0, 1); set_mode(1, 2);
    repeat (10) @(negedge clk);
    window(0, 80, nh, nl, ng, no);
    check("R5 force high gate", nh, 80);
    check("R5 force high low gate", nl, 0);
    window(1, 80, nh, nl, ng, no);
    check("R5 force low high gate", nh, 0);
    check("R5 force low low gate", nl, 80);
    set_mode(0, 0); set_mode(1, 0);
  endtask

  task automatic t_frozen();
    int nh, nl, ng, no;
    en_hi = 3'b001; en_lo = '0;
    repeat (60) @(negedge clk);
    wait_rise(0);
    repeat (2) @(negedge clk);
    set_mode(0, 3);
    repeat (3) @(negedge clk);
    window(0, 120, nh, nl, ng, no);
    check("R6 hold keeps high", nh, 120);
    set_mode(0, 0);
  endtask

  task automatic t_moe();
    int nh, nl, ng, no;
    moe = 1'b0;
    repeat (2) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      window(c, 10, nh, nl, ng, no);
      check("R10 idle high gate", nh, 10);
      check("R10 idle low gate", nl, 10);
    end
    moe = 1'b1;
  endtask

  task automatic t_preload();
    int w, p;
    en_hi = 3'b001; en_lo = '0; set_cmp(0, 12); period_i = 12'd40;
    repeat (100) @(negedge clk);
    wait_rise(0);
    set_cmp(0, 30); period_i = 12'd60;
    pulse(0, w, p);
    check("R4 running pulse keeps threshold", w, 12);
    check("R2 running period kept", p, 40);
    pulse(0, w, p);
    check("R4 next pulse new threshold", w, 30);
    check("R2 next period new", p, 60);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    t_reset();
    t_defaults();
    t_default_dt();
    t_dead();
    t_single();
    t_force();
    t_frozen();
    t_moe();
    t_preload();
    summary();
  end
endmodule